// File: doc/BRIEF.md
# Local Continuation Stack Scheduler

This block schedules the threads of one activation frame in a fine-grained, non-blocking threading engine. Pending thread entry points are held in a small last-in, first-out stack. A fork adds a continuation to the stack. A join that completes its synchronisation adds a continuation in the same way. When a thread stops, the most recent continuation is handed back as the next program counter to run.

On frame entry the stack is loaded with a single continuation, the frame-exit thread. Local work therefore drains first, and the exit code runs only once nothing else is pending. The dispatch that empties the stack also raises a swap request toward the frame-level scheduler. A fall-through fork continues straight into the next thread, so it never touches the stack.

A context port saves the stack contents one entry per cycle, bottom entry first, and holds a busy flag while it does so. The same port rebuilds the stack by clearing it and appending entries one at a time. Instruction execution, register save and restore, and the choice of the next frame are handled elsewhere.

Top module: `lcv_sched`

## Requirements
- R1: After reset the stack is empty and next_vld_o, swap_req_o, overflow_o, underflow_o and ctx_busy_o are all low.
- R2: enter_i replaces the stack contents with exactly one entry, exit_pc_i. Other requests presented in the same cycle are ignored.
- R3: A fork with fork_ft_i low pushes fork_pc_i. stop_i pops the top entry and, one cycle later, presents it on next_pc_o with a one-cycle next_vld_o pulse. Entries leave in reverse order of arrival.
- R4: A fork with fork_ft_i high pushes nothing, so the following stops return what they would have returned without it.
- R5: join_i pushes join_pc_i. When a fork and a join arrive in the same cycle, both are pushed and the join entry ends up above the fork entry.
- R6: When stop_i coincides with a push, the pushed PC is dispatched directly and the stack is not popped. If both a fork and a join are present, the join PC is dispatched and the fork PC is pushed.
- R7: swap_req_o pulses together with next_vld_o exactly when a pop takes the stack from one entry to zero. A dispatch that bypasses the stack never raises it.
- R8: The stack holds DEPTH entries (default 16). A push that does not fit is dropped, overflow_o pulses one cycle later, and the stored entries are unchanged. Of two simultaneous pushes, the fork push is kept first.
- R9: stop_i on an empty stack with no coinciding push gives an underflow_o pulse and no next_vld_o.
- R10: ctx_save_i on a non-empty stack of N entries holds ctx_busy_o high for N cycles, starting the cycle after the request. Entries are presented on ctx_out_pc_o from bottom to top, and the stack contents are kept.
- R11: While ctx_busy_o is high, fork, join, stop, enter and restore requests are ignored.
- R12: ctx_clr_i empties the stack. Each cycle with ctx_in_vld_i high appends ctx_in_pc_i on top. Precedence among requests is enter, then clear, then append, then save, then fork/join/stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_i | input | 1 | Frame entry: seed the stack with the exit continuation |
| exit_pc_i | input | PC_W | Entry point of the frame-exit thread |
| fork_i | input | 1 | Fork request |
| fork_ft_i | input | 1 | Fork targets the fall-through thread (no push) |
| fork_pc_i | input | PC_W | Forked thread PC |
| join_i | input | 1 | Join counter reached zero: enable thread |
| join_pc_i | input | PC_W | Enabled thread PC |
| stop_i | input | 1 | Current thread finished: dispatch next |
| ctx_save_i | input | 1 | Start streaming the stack out |
| ctx_clr_i | input | 1 | Empty the stack before a restore |
| ctx_in_vld_i | input | 1 | Append one restored entry |
| ctx_in_pc_i | input | PC_W | Restored entry value |
| next_vld_o | output | 1 | next_pc_o is a dispatched PC |
| next_pc_o | output | PC_W | Next thread PC |
| swap_req_o | output | 1 | Frame work exhausted: request a swap |
| overflow_o | output | 1 | A push was dropped because the stack was full |
| underflow_o | output | 1 | Stop arrived with nothing to dispatch |
| ctx_busy_o | output | 1 | Save stream in progress; ctx_out_pc_o valid |
| ctx_out_pc_o | output | PC_W | Saved entry, bottom of stack first |

## Verification
Two pairs of functions can land in the same cycle. A stop can coincide with a fork and/or a join, and a push can arrive when the stack is full. The bench drives fork with stop, and fork with join and stop, on the same clock edge. It judges the result by the PC dispatched at once, by the absence of a swap pulse, and by the order of the later stops, which must show that the stack kept its contents. It also fills the stack to its limit and pushes once more. It expects an overflow pulse, and the full drain order must show that the top entry is still the last push that fitted.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
   // request class chosen for one cycle, in precedence order
   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_SEED   = 3'd1,
      OP_CLEAR  = 3'd2,
      OP_APPEND = 3'd3,
      OP_SAVE   = 3'd4,
      OP_RUN    = 3'd5
   } lcv_op_e;
endpackage

// File: rtl/lcv_stack.sv
module lcv_stack #(
   parameter int PC_W  = 16,
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seed_i,
   input  logic [PC_W-1:0]  seed_pc_i,
   input  logic             clr_i,
   input  logic             pop_i,
   input  logic [1:0]       push_n_i,
   input  logic [PC_W-1:0]  push_d0_i,
   input  logic [PC_W-1:0]  push_d1_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [PC_W-1:0]  rd_pc_o,
   output logic [PC_W-1:0]  top_pc_o,
   output logic [CNT_W-1:0] count_o
);
   logic [CNT_W-1:0] count_q;
   logic [PC_W-1:0]  mem_q [DEPTH];
   logic [CNT_W-1:0] count_p1;
   logic [IDX_W-1:0] top_idx;

   assign count_p1 = count_q + CNT_W'(1);
   assign top_idx  = IDX_W'(count_q - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_q <= '0;
      else if (seed_i) count_q <= CNT_W'(1);
      else if (clr_i)  count_q <= '0;
      else if (pop_i)  count_q <= count_q - CNT_W'(1);
      else             count_q <= count_q + CNT_W'(push_n_i);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem_q[i] <= '0;
         else if (seed_i) begin
            if (i == 0) mem_q[i] <= seed_pc_i;
         end
         else if (!clr_i && !pop_i) begin
            if (push_n_i != 2'd0 && count_q == CNT_W'(i))
               mem_q[i] <= push_d0_i;
            else if (push_n_i == 2'd2 && count_p1 == CNT_W'(i))
               mem_q[i] <= push_d1_i;
         end
      end
   end

   assign top_pc_o = mem_q[top_idx];
   assign rd_pc_o  = mem_q[rd_idx_i];
   assign count_o  = count_q;

   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH)); // R8
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> count_q != '0); // R9
endmodule

// File: rtl/lcv_ctx_save.sv
module lcv_ctx_save #(
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             busy_o,
   output logic [IDX_W-1:0] idx_o
);
   logic             busy_q;
   logic [IDX_W-1:0] idx_q;
   logic             last;

   assign last = (CNT_W'(idx_q) + CNT_W'(1)) == count_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end
      else if (!busy_q) begin
         if (start_i && count_i != '0) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end
      end
      else begin
         if (last) busy_q <= 1'b0;
         idx_q <= idx_q + IDX_W'(1);
      end
   end

   assign busy_o = busy_q;
   assign idx_o  = idx_q;

   AST_SAVE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> CNT_W'(idx_q) < count_i); // R10
endmodule

// File: rtl/lcv_sched.sv
module lcv_sched #(
   parameter int PC_W  = 16,
   parameter int DEPTH = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enter_i,
   input  logic [PC_W-1:0] exit_pc_i,
   input  logic            fork_i,
   input  logic            fork_ft_i,
   input  logic [PC_W-1:0] fork_pc_i,
   input  logic            join_i,
   input  logic [PC_W-1:0] join_pc_i,
   input  logic            stop_i,
   input  logic            ctx_save_i,
   input  logic            ctx_clr_i,
   input  logic            ctx_in_vld_i,
   input  logic [PC_W-1:0] ctx_in_pc_i,
   output logic            next_vld_o,
   output logic [PC_W-1:0] next_pc_o,
   output logic            swap_req_o,
   output logic            overflow_o,
   output logic            underflow_o,
   output logic            ctx_busy_o,
   output logic [PC_W-1:0] ctx_out_pc_o
);
   import lcv_pkg::*;

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("lcv_sched: DEPTH must be at least 2");
   end
   if (PC_W < 1) begin : g_bad_width
      $error("lcv_sched: PC_W must be positive");
   end

   logic             busy;
   logic [IDX_W-1:0] save_idx;
   logic [CNT_W-1:0] count;
   logic [PC_W-1:0]  top_pc;
   logic [PC_W-1:0]  rd_pc;
   lcv_op_e          op;

   logic             fk, jn, st, bypass, pop, unf_evt, ovf_evt;
   logic [PC_W-1:0]  byp_pc;
   logic [1:0]       req_n, push_n;
   logic [PC_W-1:0]  d0, d1;
   logic [CNT_W-1:0] free_n;

   // request precedence
   always_comb begin
      if (busy)              op = OP_IDLE;
      else if (enter_i)      op = OP_SEED;
      else if (ctx_clr_i)    op = OP_CLEAR;
      else if (ctx_in_vld_i) op = OP_APPEND;
      else if (ctx_save_i)   op = OP_SAVE;
      else                   op = OP_RUN;
   end

   assign fk = (op == OP_RUN) && fork_i && !fork_ft_i;
   assign jn = (op == OP_RUN) && join_i;
   assign st = (op == OP_RUN) && stop_i;

   assign bypass  = st && (fk || jn);
   assign byp_pc  = jn ? join_pc_i : fork_pc_i;
   assign pop     = st && !fk && !jn && (count != '0);
   assign unf_evt = st && !fk && !jn && (count == '0);

   // pushes that must reach the stack this cycle
   always_comb begin
      d0    = fork_pc_i;
      d1    = join_pc_i;
      req_n = 2'd0;
      if (op == OP_APPEND) begin
         d0    = ctx_in_pc_i;
         req_n = 2'd1;
      end
      else if (st) begin
         req_n = (fk && jn) ? 2'd1 : 2'd0;
      end
      else begin
         req_n = {1'b0, fk} + {1'b0, jn};
         d0    = fk ? fork_pc_i : join_pc_i;
      end
   end

   assign free_n  = CNT_W'(DEPTH) - count;
   assign ovf_evt = CNT_W'(req_n) > free_n;
   assign push_n  = ovf_evt ? free_n[1:0] : req_n;

   lcv_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .seed_i    (op == OP_SEED),
      .seed_pc_i (exit_pc_i),
      .clr_i     (op == OP_CLEAR),
      .pop_i     (pop),
      .push_n_i  (push_n),
      .push_d0_i (d0),
      .push_d1_i (d1),
      .rd_idx_i  (save_idx),
      .rd_pc_o   (rd_pc),
      .top_pc_o  (top_pc),
      .count_o   (count)
   );

   lcv_ctx_save #(.DEPTH(DEPTH)) u_save (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (op == OP_SAVE),
      .count_i (count),
      .busy_o  (busy),
      .idx_o   (save_idx)
   );

   logic            vld_q, swap_q, ovf_q, unf_q;
   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         pc_q   <= '0;
         swap_q <= 1'b0;
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
      end
      else begin
         vld_q  <= bypass || pop;
         if (bypass)   pc_q <= byp_pc;
         else if (pop) pc_q <= top_pc;
         swap_q <= pop && (count == CNT_W'(1));
         ovf_q  <= ovf_evt;
         unf_q  <= unf_evt;
      end
   end

   assign next_vld_o   = vld_q;
   assign next_pc_o    = pc_q;
   assign swap_req_o   = swap_q;
   assign overflow_o   = ovf_q;
   assign underflow_o  = unf_q;
   assign ctx_busy_o   = busy;
   assign ctx_out_pc_o = rd_pc;

   AST_SWAP_WITH_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
      swap_q |-> vld_q); // R7
   AST_NO_DISPATCH_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(vld_q && unf_q)); // R9
   AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(count)); // R11
   AST_SEED_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SEED) |=> (count == CNT_W'(1))); // R2
   AST_BYPASS_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && !(fk && jn)) |=> $stable(count)); // R6
endmodule

// File: tb/lcv_sched_test.sv
module lcv_sched_test;
   localparam int PC_W  = 16;
   localparam int DEPTH = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            enter_i = 0, fork_i = 0, fork_ft_i = 0, join_i = 0, stop_i = 0;
   logic            ctx_save_i = 0, ctx_clr_i = 0, ctx_in_vld_i = 0;
   logic [PC_W-1:0] exit_pc_i = '0, fork_pc_i = '0, join_pc_i = '0, ctx_in_pc_i = '0;
   logic            next_vld_o, swap_req_o, overflow_o, underflow_o, ctx_busy_o;
   logic [PC_W-1:0] next_pc_o, ctx_out_pc_o;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   lcv_sched #(.PC_W(PC_W), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n),
      .enter_i(enter_i), .exit_pc_i(exit_pc_i),
      .fork_i(fork_i), .fork_ft_i(fork_ft_i), .fork_pc_i(fork_pc_i),
      .join_i(join_i), .join_pc_i(join_pc_i), .stop_i(stop_i),
      .ctx_save_i(ctx_save_i), .ctx_clr_i(ctx_clr_i),
      .ctx_in_vld_i(ctx_in_vld_i), .ctx_in_pc_i(ctx_in_pc_i),
      .next_vld_o(next_vld_o), .next_pc_o(next_pc_o), .swap_req_o(swap_req_o),
      .overflow_o(overflow_o), .underflow_o(underflow_o),
      .ctx_busy_o(ctx_busy_o), .ctx_out_pc_o(ctx_out_pc_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one clock with the current inputs, then all requests released
   task automatic tick();
      @(negedge clk);
      enter_i = 0; fork_i = 0; fork_ft_i = 0; join_i = 0; stop_i = 0;
      ctx_save_i = 0; ctx_clr_i = 0; ctx_in_vld_i = 0;
   endtask

   task automatic do_enter(logic [PC_W-1:0] pc);
      enter_i = 1; exit_pc_i = pc; tick();
   endtask

   task automatic do_fork(logic [PC_W-1:0] pc);
      fork_i = 1; fork_pc_i = pc; tick();
   endtask

   // stop and compare the dispatch that follows
   task automatic do_stop(string req, logic [PC_W-1:0] pc, logic swp);
      stop_i = 1; tick();
      check(req, {31'd0, next_vld_o}, 32'd1);
      check(req, {16'd0, next_pc_o}, {16'd0, pc});
      check(req, {31'd0, swap_req_o}, {31'd0, swp});
   endtask

   task automatic t_reset();
      check("R1 vld", {31'd0, next_vld_o}, 0);
      check("R1 swap", {31'd0, swap_req_o}, 0);
      check("R1 ovf", {31'd0, overflow_o}, 0);
      check("R1 busy", {31'd0, ctx_busy_o}, 0);
      stop_i = 1; tick();
      check("R9 underflow", {31'd0, underflow_o}, 1);
      check("R9 no vld", {31'd0, next_vld_o}, 0);
   endtask

   task automatic t_enter();
      fork_i = 1; fork_pc_i = 16'h0444; do_enter(16'hE000);
      do_stop("R2 R7 exit", 16'hE000, 1);
      stop_i = 1; tick();
      check("R2 only one entry", {31'd0, underflow_o}, 1);
   endtask

   task automatic t_lifo();
      do_enter(16'hE001);
      do_fork(16'h0010);
      do_fork(16'h0020);
      fork_ft_i = 1; do_fork(16'h0099);
      do_stop("R3 R4 top", 16'h0020, 0);
      do_stop("R3 second", 16'h0010, 0);
      do_stop("R3 R7 exit", 16'hE001, 1);
   endtask

   task automatic t_join_pair();
      do_enter(16'hE002);
      join_i = 1; join_pc_i = 16'h0B0B; do_fork(16'h0A0A);
      do_stop("R5 join on top", 16'h0B0B, 0);
      do_stop("R5 fork below", 16'h0A0A, 0);
      do_stop("R5 exit", 16'hE002, 1);
   endtask

   task automatic t_bypass();
      do_enter(16'hE003);
      stop_i = 1; do_fork(16'h0C0C);
      check("R6 bypass vld", {31'd0, next_vld_o}, 1);
      check("R6 bypass pc", {16'd0, next_pc_o}, 16'h0C0C);
      check("R7 no swap on bypass", {31'd0, swap_req_o}, 0);
      stop_i = 1; join_i = 1; join_pc_i = 16'h0D0D; do_fork(16'h0E0E);
      check("R6 join bypass pc", {16'd0, next_pc_o}, 16'h0D0D);
      do_stop("R6 fork kept", 16'h0E0E, 0);
      do_stop("R6 stack untouched", 16'hE003, 1);
   endtask

   task automatic t_overflow();
      do_enter(16'hE004);
      for (int i = 0; i < DEPTH - 1; i++) do_fork(16'h0100 + 16'(i));
      check("R8 no ovf at full", {31'd0, overflow_o}, 0);
      do_fork(16'h02FF);
      check("R8 overflow", {31'd0, overflow_o}, 1);
      for (int i = DEPTH - 2; i >= 0; i--) do_stop("R8 drain", 16'h0100 + 16'(i), 0);
      do_stop("R8 exit", 16'hE004, 1);
   endtask

   task automatic t_save();
      do_enter(16'hE005);
      do_fork(16'h0051);
      do_fork(16'h0052);
      ctx_save_i = 1; tick();
      check("R10 busy", {31'd0, ctx_busy_o}, 1);
      check("R10 entry0", {16'd0, ctx_out_pc_o}, 16'hE005);
      stop_i = 1; tick();
      check("R11 stop ignored", {31'd0, next_vld_o}, 0);
      check("R10 entry1", {16'd0, ctx_out_pc_o}, 16'h0051);
      fork_i = 1; fork_pc_i = 16'h0777; tick();
      check("R10 entry2", {16'd0, ctx_out_pc_o}, 16'h0052);
      check("R10 busy last", {31'd0, ctx_busy_o}, 1);
      tick();
      check("R10 busy ends", {31'd0, ctx_busy_o}, 0);
      do_stop("R10 R11 kept", 16'h0052, 0);
      do_stop("R10 kept", 16'h0051, 0);
      do_stop("R10 exit", 16'hE005, 1);
   endtask

   task automatic t_restore();
      do_enter(16'hE006);
      ctx_clr_i = 1; tick();
      stop_i = 1; tick();
      check("R12 cleared", {31'd0, underflow_o}, 1);
      ctx_in_vld_i = 1; ctx_in_pc_i = 16'h0061; tick();
      ctx_in_vld_i = 1; ctx_in_pc_i = 16'h0062; tick();
      ctx_in_vld_i = 1; ctx_in_pc_i = 16'h0063; tick();
      do_stop("R12 top", 16'h0063, 0);
      do_stop("R12 mid", 16'h0062, 0);
      do_stop("R12 bottom", 16'h0061, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_enter();
      t_lifo();
      t_join_pair();
      t_bypass();
      t_overflow();
      t_save();
      t_restore();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule